// File: doc/BRIEF.md
# Chien Search Error Locator

This block takes the coefficients of a BCH error-locator polynomial, produced elsewhere, and finds the bit positions where that polynomial has a root. A host stops the engine, writes up to `T_MAX+1` coefficients and a configuration word, then writes the search length. Writing the length starts the search. The block then evaluates the polynomial at alpha^1, alpha^2, … alpha^LEN, one position per clock. Each position that gives zero is recorded in increasing order. When the last position has been tested, a done flag is set in the status word, together with a count of the roots found.

Two Galois fields are supported. The narrow field has m = 13 and serves 512-byte sectors. The wide field has m = 14 and serves 1024-byte sectors. For a real sector, the host programs the length as sector_bytes*8 + m*t.

Reported positions are one-based. The host subtracts one, then takes the byte as the quotient by 8 and the bit as the remainder. Bytes below the sector size are data. Bytes below the sector size plus the ECC byte count are parity. Anything beyond that is invalid. The host rejects the whole sector as uncorrectable when the root count differs from the locator degree.

Top module: `chien_search`

## Requirements
- R1: After reset, the status word (address 0x03) reads zero and every position slot (addresses 0x20 + i) reads zero.
- R2: Coefficient j is written at address 0x10 + j, in bits 13:0. A position p with 1 <= p <= LEN is reported if and only if sum_j sigma_j * alpha^(p*j) = 0. Alpha is a root of x^13+x^4+x^3+x+1 when configuration bit 0 is 0, and of x^14+x^10+x^6+x+1 when configuration bit 0 is 1. In the narrow field, coefficient bit 13 is ignored.
- R3: Configuration bits 20:16 (address 0x01) hold the number of coefficients in use minus one. Coefficients at a higher index are treated as zero, whatever was written to them.
- R4: A write to the length register (address 0x02, bits 14:0) starts a search. Status bit 0 (done) is set on the clock edge LEN edges after the edge that accepted the write. With LEN = 0, done is set on that same edge and no root is reported.
- R5: Found positions fill slots 0x20, 0x21, … in increasing order. Slots that are not filled read zero. Status bits 12:8 give the number of roots stored.
- R6: At most T_MAX positions are stored. Further roots are dropped, and the root count saturates at T_MAX.
- R7: Writing 1 to bit 0 of the control register (address 0x00) aborts any search and clears done, the root count and all slots. Writing 0 to that bit has no effect.
- R8: While a search runs, writes to the configuration, length and coefficient registers are ignored.
- R9: Starting a new search clears the results of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
The situation hardest to reach from the ports is the one that fills the store past its capacity. A polynomial of degree T_MAX or less has at most T_MAX distinct roots, so no genuine locator can overflow the store. The bench gets there by loading an all-zero locator: the evaluation is then zero at every position, so every position is a root and the store saturates. Register writes made during a search are also awkward to observe. They are exposed by timing the search and by repeating it with the length alone rewritten, which shows that the coefficients and field selection were left untouched.

// File: rtl/chien_pkg.sv
// Shared constants and field arithmetic for the Chien search engine.
// Assumes field elements are carried in 14 bits; the narrow field keeps bit 13 at zero.
package chien_pkg;
    localparam int GF_W   = 14;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    // Reduction terms (polynomial minus its leading power)
    localparam logic [GF_W-1:0] RED_NARROW = 14'h001b;
    localparam logic [GF_W-1:0] RED_WIDE   = 14'h0443;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_CFG  = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_LEN  = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_STAT = 6'h03;
    localparam logic [ADDR_W-1:0] ADR_SIG0 = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_POS0 = 6'h20;

    // Field positions in configuration and status words
    localparam int CFG_WIDE_BIT = 0;
    localparam int CFG_CNT_LSB  = 16;
    localparam int CFG_CNT_W    = 5;
    localparam int STAT_CNT_LSB = 8;

    // Multiply one element by alpha in the selected field
    function automatic logic [GF_W-1:0] gf_alpha_step(input logic [GF_W-1:0] v,
                                                      input logic wide);
        logic [GF_W-1:0] r;
        if (wide) begin
            r = {v[GF_W-2:0], 1'b0};
            if (v[GF_W-1]) r = r ^ RED_WIDE;
        end else begin
            r = {1'b0, v[GF_W-3:0], 1'b0};
            if (v[GF_W-2]) r = r ^ RED_NARROW;
        end
        return r;
    endfunction
endpackage

// File: rtl/chien_coef_cell.sv
// One locator term register. On load it takes the coefficient; on every
// step it is multiplied by alpha^POWER. term_next shows the value of the
// term at the next evaluation point.
// Assumes wide is held constant while step is asserted.
module chien_coef_cell
    import chien_pkg::*;
#(
    parameter int POWER = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            wide,
    input  logic [GF_W-1:0] seed,
    output logic [GF_W-1:0] term_next
);
    logic [GF_W-1:0] term_q;

    // Constant multiply by alpha^POWER as POWER chained alpha steps
    always_comb begin
        term_next = term_q;
        for (int k = 0; k < POWER; k++) begin
            term_next = gf_alpha_step(term_next, wide);
        end
    end

    // Term register: load seed or advance one position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= '0;
        end else if (load) begin
            term_q <= seed;
        end else if (step) begin
            term_q <= term_next;
        end
    end
endmodule

// File: rtl/chien_seq.sv
// Search sequencer. It latches the length on start, counts the evaluated
// positions and raises done once the last one is tested. stop has priority.
// Assumes start is not asserted while busy.
module chien_seq #(
    parameter int LEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [LEN_W-1:0] len_in,
    output logic             busy,
    output logic             done,
    output logic [LEN_W-1:0] pos,
    output logic [LEN_W-1:0] len_q
);
    logic [LEN_W-1:0] pos_next;

    // Next position index
    assign pos_next = pos + 1'b1;

    // Busy/done/position state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            pos   <= '0;
            len_q <= '0;
        end else if (stop) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            pos   <= '0;
            len_q <= len_in;
            if (len_in == '0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                busy <= 1'b1;
                done <= 1'b0;
            end
        end else if (busy) begin
            pos <= pos_next;
            if (pos_next == len_q) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chien_root_store.sv
// Result store. Hits fill slots in arrival order, so the slots come out in
// increasing position order. The count saturates at SLOTS; clear empties all.
// Assumes hit positions arrive in increasing order.
module chien_root_store #(
    parameter int SLOTS = 8,
    parameter int LEN_W = 15,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        hit,
    input  logic [LEN_W-1:0]            hit_pos,
    output logic [CNT_W-1:0]            count,
    output logic [SLOTS-1:0][LEN_W-1:0] slot
);
    logic room;

    // Space left for another root
    assign room = (count < CNT_W'(SLOTS));

    // Saturating root counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (hit && room) begin
            count <= count + 1'b1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Slot i captures the i-th hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (clear) begin
                slot[i] <= '0;
            end else if (hit && count == CNT_W'(i)) begin
                slot[i] <= hit_pos;
            end
        end
    end
endmodule

// File: rtl/chien_search.sv
// Chien search top. It decodes register writes, holds the coefficients and
// field selection, runs one evaluation per clock through T_MAX+1 term cells,
// and records the zero positions. Reads are combinational.
// Assumes T_MAX <= 15 (address map) and LEN <= 2^m - 1.
module chien_search
    import chien_pkg::*;
#(
    parameter int T_MAX = 8,
    parameter int LEN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NCOEF = T_MAX + 1;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic                        busy, done;
    logic [LEN_W-1:0]            pos, seq_len;
    logic                        wr_ok, stop_req, start_req, clear;
    logic                        wide_q;
    logic [CFG_CNT_W-1:0]        ncoef_m1_q;
    logic [GF_W-1:0]             sig_q     [NCOEF];
    logic [GF_W-1:0]             seed      [NCOEF];
    logic [GF_W-1:0]             term_next [NCOEF];
    logic [GF_W-1:0]             eval_sum;
    logic                        hit;
    logic [CNT_W-1:0]            root_cnt;
    logic [T_MAX-1:0][LEN_W-1:0] slot;
    logic                        unused_bits;

    assign unused_bits = ^{wr_data[DATA_W-1:CFG_CNT_LSB+CFG_CNT_W], wr_data[LEN_W]};

    // Write qualification: setup writes only while idle
    assign wr_ok     = wr_en && !busy;
    assign stop_req  = wr_en && (wr_addr == ADR_CTRL) && wr_data[0];
    assign start_req = wr_ok && (wr_addr == ADR_LEN);
    assign clear     = stop_req || start_req;

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q     <= 1'b0;
            ncoef_m1_q <= '0;
        end else if (wr_ok && wr_addr == ADR_CFG) begin
            wide_q     <= wr_data[CFG_WIDE_BIT];
            ncoef_m1_q <= wr_data[CFG_CNT_LSB +: CFG_CNT_W];
        end
    end

    for (genvar j = 0; j < NCOEF; j++) begin : g_coef
        // Coefficient register j
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sig_q[j] <= '0;
            end else if (wr_ok && wr_addr == ADR_SIG0 + ADDR_W'(j)) begin
                sig_q[j] <= wr_data[GF_W-1:0];
            end
        end

        // Seed: unused coefficients and the narrow-field top bit are masked
        always_comb begin
            if (CFG_CNT_W'(j) > ncoef_m1_q) begin
                seed[j] = '0;
            end else if (wide_q) begin
                seed[j] = sig_q[j];
            end else begin
                seed[j] = {1'b0, sig_q[j][GF_W-2:0]};
            end
        end

        chien_coef_cell #(.POWER(j)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (start_req),
            .step      (busy),
            .wide      (wide_q),
            .seed      (seed[j]),
            .term_next (term_next[j])
        );
    end

    // Locator value at the next position
    always_comb begin
        eval_sum = '0;
        for (int j = 0; j < NCOEF; j++) begin
            eval_sum = eval_sum ^ term_next[j];
        end
    end

    assign hit = busy && (eval_sum == '0);

    chien_seq #(.LEN_W(LEN_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_req),
        .stop   (stop_req),
        .len_in (wr_data[LEN_W-1:0]),
        .busy   (busy),
        .done   (done),
        .pos    (pos),
        .len_q  (seq_len)
    );

    chien_root_store #(.SLOTS(T_MAX), .LEN_W(LEN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .hit     (hit),
        .hit_pos (pos + 1'b1),
        .count   (root_cnt),
        .slot    (slot)
    );

    // Read mux for status and position slots
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_STAT) begin
            rd_data[0]                     = done;
            rd_data[STAT_CNT_LSB +: CNT_W] = root_cnt;
        end
        for (int i = 0; i < T_MAX; i++) begin
            if (rd_addr == ADR_POS0 + ADDR_W'(i)) begin
                rd_data = DATA_W'(slot[i]);
            end
        end
    end
endmodule

// File: rtl/chien_search_chk.sv
// Property checker for chien_search, attached by bind. It watches the
// sequencer, store and configuration state across cycles.
module chien_search_chk
    import chien_pkg::*;
#(
    parameter int T_MAX = 8,
    parameter int LEN_W = 15,
    localparam int CNT_W = $clog2(T_MAX + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic [LEN_W-1:0]     pos,
    input logic [LEN_W-1:0]     seq_len,
    input logic [CNT_W-1:0]     root_cnt,
    input logic                 stop_req,
    input logic                 start_req,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 wide_q,
    input logic [CFG_CNT_W-1:0] ncoef_m1_q
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!done && root_cnt == '0)); // R7
    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop_req) |=> (pos == $past(pos) + 1'b1)); // R4
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (pos == seq_len)); // R4
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        root_cnt <= CNT_W'(T_MAX)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == ADR_CFG) |=> ($stable(wide_q) && $stable(ncoef_m1_q))); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (root_cnt == '0)); // R9
endmodule

bind chien_search chien_search_chk #(.T_MAX(T_MAX), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .pos        (pos),
    .seq_len    (seq_len),
    .root_cnt   (root_cnt),
    .stop_req   (stop_req),
    .start_req  (start_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wide_q     (wide_q),
    .ncoef_m1_q (ncoef_m1_q)
);

// File: tb/chien_search_test.sv
`timescale 1ns/1ps
module chien_search_test;
    localparam int T = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int errors = 0;
    int total  = 0;
    int rts [16];
    int nr;
    logic [13:0] sg [T+1];

    always #2 clk = ~clk;

    chien_search uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Field arithmetic computed from the field polynomials
    function automatic int xt(input int v, input bit wide);
        int m = wide ? 14 : 13;
        int p = wide ? 'h4443 : 'h201b;
        int r = v << 1;
        if ((r >> m) & 1) r = r ^ p;
        return r;
    endfunction

    function automatic int gmul(input int a, input int b, input bit wide);
        int r = 0;
        int x = a;
        for (int i = 0; i < 14; i++) begin
            if ((b >> i) & 1) r = r ^ x;
            x = xt(x, wide);
        end
        return r;
    endfunction

    function automatic int apow(input int p, input bit wide);
        int v = 1;
        for (int i = 0; i < p; i++) v = xt(v, wide);
        return v;
    endfunction

    // All tasks are entered between a falling and the next rising edge
    task automatic wr(input logic [5:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_done(output int n);
        int s;
        n = 0;
        rd(6'h03, s);
        while (!s[0] && n < 20000) begin
            @(negedge clk);
            n++;
            rd(6'h03, s);
        end
    endtask

    task automatic load_sigma(input bit wide, input bit junk);
        int c [T+1];
        for (int j = 0; j <= T; j++) c[j] = 0;
        c[0] = 1;
        for (int e = 0; e < nr; e++) begin
            int a = apow(rts[e], wide);
            for (int j = T; j >= 1; j--) c[j] = c[j-1] ^ gmul(a, c[j], wide);
            c[0] = gmul(a, c[0], wide);
        end
        for (int j = 0; j <= T; j++) sg[j] = 14'(c[j]);
        wr(6'h01, (nr << 16) | int'(wide));
        for (int j = 0; j <= T; j++) wr(6'h10 + 6'(j), int'(sg[j]));
        if (junk) wr(6'h15, 'h1abc); // R3: beyond the count field
    endtask

    task automatic check_results(input string req, input int len);
        int ex [T];
        int cnt = 0;
        int s, v;
        for (int i = 0; i < T; i++) ex[i] = 0;
        for (int e = 0; e < nr; e++) begin
            if (rts[e] <= len && cnt < T) begin
                ex[cnt] = rts[e];
                cnt++;
            end
        end
        rd(6'h03, s);
        chk(((s >> 8) & 'h1f) == cnt, req, "R5 root count", (s >> 8) & 'h1f, cnt);
        for (int i = 0; i < T; i++) begin
            rd(6'h20 + 6'(i), v);
            chk(v == ex[i], req, "R5 slot", v, ex[i]);
        end
    endtask

    task automatic do_search(input string req, input int len, input bit wide, input bit junk);
        int n;
        load_sigma(wide, junk);
        wr(6'h02, len);
        wait_done(n);
        chk(n == len, req, "R4 edges to done", n, len);
        check_results(req, len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(6'h03, v);
        chk(v == 0, "R1", "status after reset", v, 0);
        for (int i = 0; i < T; i++) begin
            rd(6'h20 + 6'(i), v);
            chk(v == 0, "R1", "slot after reset", v, 0);
        end

        // R2 R4 R5: single root swept over and past the length, both fields
        for (int w = 0; w < 2; w++) begin
            for (int p = 1; p <= 26; p++) begin
                nr = 1; rts[0] = p;
                do_search("R2", 24, w[0], 1'b0);
            end
        end

        // R2 R5: several roots, including one at the last position and one past it
        nr = 3; rts[0] = 5; rts[1] = 17; rts[2] = 40;
        do_search("R2", 40, 1'b0, 1'b0);
        nr = 3; rts[0] = 5; rts[1] = 17; rts[2] = 41;
        do_search("R2", 40, 1'b1, 1'b0);
        nr = 8; rts = '{2, 9, 15, 16, 22, 30, 31, 33, 0, 0, 0, 0, 0, 0, 0, 0};
        do_search("R5", 33, 1'b0, 1'b0);
        nr = 8; rts = '{1, 2, 3, 4, 5, 6, 7, 8, 0, 0, 0, 0, 0, 0, 0, 0};
        do_search("R5", 20, 1'b1, 1'b0);

        // R2: full sector lengths in each field
        nr = 3; rts[0] = 1; rts[1] = 2000; rts[2] = 4200;
        do_search("R2", 4096 + 13 * 8, 1'b0, 1'b0);
        nr = 3; rts[0] = 7; rts[1] = 5000; rts[2] = 8304;
        do_search("R2", 8192 + 14 * 8, 1'b1, 1'b0);

        // R3: coefficient beyond the declared count is ignored
        nr = 2; rts[0] = 4; rts[1] = 9;
        do_search("R3", 12, 1'b0, 1'b1);
        nr = 2; rts[0] = 4; rts[1] = 9;
        do_search("R3", 12, 1'b1, 1'b1);

        // R6: all-zero locator makes every position a root
        wr(6'h01, 0);
        for (int j = 0; j <= T; j++) wr(6'h10 + 6'(j), 0);
        wr(6'h02, 20);
        wait_done(n);
        chk(n == 20, "R6", "edges to done", n, 20);
        nr = 20;
        for (int i = 0; i < 16; i++) rts[i] = i + 1;
        check_results("R6", 20);

        // R4: zero length finishes on the write edge with no roots
        wr(6'h02, 0);
        wait_done(n);
        chk(n == 0, "R4", "zero length edges", n, 0);
        rd(6'h03, v);
        chk(v == 1, "R4", "zero length status", v, 1);

        // R7: stop part way through a search
        nr = 2; rts[0] = 3; rts[1] = 50;
        load_sigma(1'b0, 1'b0);
        wr(6'h02, 200);
        repeat (60) @(negedge clk);
        wr(6'h00, 1);
        rd(6'h03, v);
        chk(v == 0, "R7", "status after stop", v, 0);
        rd(6'h20, v);
        chk(v == 0, "R7", "slot after stop", v, 0);
        repeat (200) @(negedge clk);
        rd(6'h03, v);
        chk(v == 0, "R7", "no completion after stop", v, 0);
        // R7: writing zero to the control bit leaves results alone
        wr(6'h02, 60);
        wait_done(n);
        wr(6'h00, 0);
        check_results("R7", 60);
        rd(6'h03, v);
        chk(v[0] == 1'b1, "R7", "done kept", v & 1, 1);

        // R8: setup writes during a search are ignored
        nr = 2; rts[0] = 3; rts[1] = 10;
        load_sigma(1'b0, 1'b0);
        wr(6'h02, 30);
        wr(6'h10, 'h55);
        wr(6'h01, 'h00070001);
        wr(6'h02, 5);
        wait_done(n);
        chk(n + 3 == 30, "R8", "length kept", n + 3, 30);
        check_results("R8", 30);
        // R8 R9: rerun with only the length rewritten
        wr(6'h02, 30);
        rd(6'h03, v);
        chk(v == 0, "R9", "status cleared by start", v, 0);
        wait_done(n);
        chk(n == 30, "R8", "rerun edges", n, 30);
        check_results("R8", 30);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule